// File: doc/BRIEF.md
# Control Transfer Stage Tracker

This block sits on the device side of a USB controller and follows the progress of a control transfer on endpoint 0. It receives decoded, single-cycle event strobes: a SETUP packet arrived, an IN data packet completed, an OUT data packet completed, the status handshake finished, or the bus was reset. With each SETUP it also receives the direction bit and the length field of that setup packet. From these events it keeps a 3-bit stage code that software can read.

It also keeps two sticky flags that software can read. The setup-valid flag records that a setup packet was seen. The stage-change flag records that the stage code moved. Software clears either flag by writing 0 to its bit and 1 to the other bit, and a written 1 never changes a flag. The stage-change flag drives an interrupt output when the enable input is high.

A mode input selects host operation. In host mode the tracker stays in the idle code and raises neither flag.

Top module: `ctlStageTop`

## Requirements
- R1: After reset the stage code is 000 and setupValid, stageChg and stageIrq are all 0.
- R2: In function mode a SETUP moves the stage according to the setup fields. With setupDirIn=1 (device-to-host) it goes to 001, whatever the length. With setupDirIn=0 and a nonzero setupLen it goes to 011. With setupDirIn=0 and setupLen=0 it goes to 101.
- R3: In stage 001 an OUT completion moves the stage to 010 and an IN completion leaves it at 001. In stage 011 an IN completion moves the stage to 100 and an OUT completion leaves it at 011.
- R4: A status completion in stage 010, 100 or 101 returns the stage to 000.
- R5: Any event that does not fit the current stage sets the stage to 110. This covers an IN, OUT or status event while idle, a status event during a data stage, and a data event during a status stage. Stage 110 is left only by a SETUP or a bus reset. Code 111 never appears.
- R6: A SETUP in any stage, including 110, restarts tracking and sets setupValid to 1.
- R7: A write with swWrEn=1 clears setupValid when swWrData[0]=0. When swWrData[0]=1 the write leaves setupValid unchanged. If a SETUP arrives in the same cycle, it wins and setupValid ends at 1.
- R8: Every change of the stage code sets stageChg to 1. A write with swWrData[1]=0 clears it, and swWrData[1]=1 leaves it unchanged. If a stage change happens in the same cycle as the clearing write, the change wins.
- R9: stageIrq equals stageChg AND intEnable.
- R10: While hostMode=1 the stage is held at 000, and events set neither setupValid nor stageChg.
- R11: A bus reset sets the stage to 000 and clears setupValid. It takes priority over a SETUP in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostMode | input | 1 | 1 selects host operation, 0 selects function operation |
| evSetup | input | 1 | SETUP packet received (one-cycle strobe) |
| evInDone | input | 1 | IN data packet completed on endpoint 0 |
| evOutDone | input | 1 | OUT data packet completed on endpoint 0 |
| evStatusDone | input | 1 | Status handshake completed |
| evBusReset | input | 1 | USB bus reset detected |
| setupDirIn | input | 1 | Setup direction, 1 means device-to-host; qualified by evSetup |
| setupLen | input | LEN_W | Setup length field; qualified by evSetup |
| swWrEn | input | 1 | Software write strobe for the status flags |
| swWrData | input | 2 | Write data: bit 0 is setupValid, bit 1 is stageChg; a 0 clears the bit |
| intEnable | input | 1 | Enables the stage-change interrupt |
| stageCode | output | 3 | Current stage code |
| setupValid | output | 1 | Setup-received flag |
| stageChg | output | 1 | Sticky stage-change flag |
| stageIrq | output | 1 | Stage-change interrupt request |

## Verification
The assertions take for granted that at most one of the SETUP, IN, OUT and status strobes is high in a cycle. A bus reset may coincide with a SETUP, and the priority rule then applies. They also take for granted that the setup fields are stable while evSetup is high. The stimulus drives a single event per cycle, except for the one deliberate collision of a bus reset with a SETUP. Every strobe is released at the next falling edge, so each event is seen at exactly one rising edge.

// File: rtl/ctsPkg.sv
package ctsPkg;
  typedef enum logic [2:0] {
    STG_IDLE     = 3'b000,
    STG_RD_DATA  = 3'b001,
    STG_RD_STAT  = 3'b010,
    STG_WR_DATA  = 3'b011,
    STG_WR_STAT  = 3'b100,
    STG_WR_NODAT = 3'b101,
    STG_SEQ_ERR  = 3'b110
  } stage_e;

  localparam int WR_VALID_BIT = 0;
  localparam int WR_CHG_BIT   = 1;
  localparam int WR_W         = 2;

  typedef struct packed {
    logic setValid;
    logic clrValid;
    logic setChg;
  } strobe_t;
endpackage

// File: rtl/ctsControl.sv
module ctsControl
  import ctsPkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostMode,
  input  logic             evSetup,
  input  logic             evInDone,
  input  logic             evOutDone,
  input  logic             evStatusDone,
  input  logic             evBusReset,
  input  logic             setupDirIn,
  input  logic [LEN_W-1:0] setupLen,
  output stage_e           stage,
  output strobe_t          strobe
);
  stage_e nextStage;
  stage_e setupTarget;

  always_comb begin
    if (setupDirIn)            setupTarget = STG_RD_DATA;
    else if (setupLen != '0)   setupTarget = STG_WR_DATA;
    else                       setupTarget = STG_WR_NODAT;
  end

  always_comb begin
    nextStage = stage;
    if (hostMode || evBusReset) begin
      nextStage = STG_IDLE;
    end else if (evSetup) begin
      nextStage = setupTarget;
    end else if (evInDone) begin
      unique case (stage)
        STG_RD_DATA: nextStage = STG_RD_DATA;
        STG_WR_DATA: nextStage = STG_WR_STAT;
        default:     nextStage = STG_SEQ_ERR;
      endcase
    end else if (evOutDone) begin
      unique case (stage)
        STG_RD_DATA: nextStage = STG_RD_STAT;
        STG_WR_DATA: nextStage = STG_WR_DATA;
        default:     nextStage = STG_SEQ_ERR;
      endcase
    end else if (evStatusDone) begin
      unique case (stage)
        STG_RD_STAT, STG_WR_STAT, STG_WR_NODAT: nextStage = STG_IDLE;
        default:                                nextStage = STG_SEQ_ERR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage <= STG_IDLE;
    else       stage <= nextStage;
  end

  always_comb begin
    strobe.setValid = evSetup && !evBusReset && !hostMode;
    strobe.clrValid = evBusReset;
    strobe.setChg   = !hostMode && (nextStage != stage);
  end

  assert_setup_target_R2: assert property (@(posedge clk) disable iff (!rstN)
    (evSetup && !evBusReset && !hostMode && setupDirIn) |=> stage == STG_RD_DATA);

  assert_err_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stage == STG_SEQ_ERR && !evSetup && !evBusReset && !hostMode) |=> stage == STG_SEQ_ERR);

  assert_host_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    hostMode |=> stage == STG_IDLE);

  assert_bus_reset_R11: assert property (@(posedge clk) disable iff (!rstN)
    evBusReset |=> stage == STG_IDLE);
endmodule

// File: rtl/ctsDatapath.sv
module ctsDatapath
  import ctsPkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         strobe,
  input  logic            swWrEn,
  input  logic [WR_W-1:0] swWrData,
  input  logic            intEnable,
  output logic            validFlag,
  output logic            chgFlag,
  output logic            irqOut
);
  logic clrValidSw;
  logic clrChgSw;

  assign clrValidSw = swWrEn && !swWrData[WR_VALID_BIT];
  assign clrChgSw   = swWrEn && !swWrData[WR_CHG_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                validFlag <= 1'b0;
    else if (strobe.clrValid) validFlag <= 1'b0;
    else if (strobe.setValid) validFlag <= 1'b1;
    else if (clrValidSw)      validFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              chgFlag <= 1'b0;
    else if (strobe.setChg) chgFlag <= 1'b1;
    else if (clrChgSw)      chgFlag <= 1'b0;
  end

  assign irqOut = chgFlag && intEnable;

  assert_valid_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setValid |=> validFlag);

  assert_valid_keep_R7: assert property (@(posedge clk) disable iff (!rstN)
    (validFlag && swWrEn && swWrData[WR_VALID_BIT] && !strobe.clrValid) |=> validFlag);

  assert_chg_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setChg |=> chgFlag);

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    !chgFlag |-> !irqOut);
endmodule

// File: rtl/ctlStageTop.sv
module ctlStageTop
  import ctsPkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostMode,
  input  logic             evSetup,
  input  logic             evInDone,
  input  logic             evOutDone,
  input  logic             evStatusDone,
  input  logic             evBusReset,
  input  logic             setupDirIn,
  input  logic [LEN_W-1:0] setupLen,
  input  logic             swWrEn,
  input  logic [1:0]       swWrData,
  input  logic             intEnable,
  output logic [2:0]       stageCode,
  output logic             setupValid,
  output logic             stageChg,
  output logic             stageIrq
);
  stage_e  stage;
  strobe_t strobe;

  ctsControl #(.LEN_W(LEN_W)) uCtl (
    .clk(clk), .rstN(rstN), .hostMode(hostMode),
    .evSetup(evSetup), .evInDone(evInDone), .evOutDone(evOutDone),
    .evStatusDone(evStatusDone), .evBusReset(evBusReset),
    .setupDirIn(setupDirIn), .setupLen(setupLen),
    .stage(stage), .strobe(strobe)
  );

  ctsDatapath uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .swWrEn(swWrEn), .swWrData(swWrData), .intEnable(intEnable),
    .validFlag(setupValid), .chgFlag(stageChg), .irqOut(stageIrq)
  );

  assign stageCode = stage;

  assert_no_code7_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stageChg) |-> stageCode != 3'b111);
endmodule

// File: tb/sim_ctlStageTop.sv
module sim_ctlStageTop;
  localparam int LEN_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostMode = 1'b0, evSetup = 1'b0, evInDone = 1'b0, evOutDone = 1'b0;
  logic evStatusDone = 1'b0, evBusReset = 1'b0, setupDirIn = 1'b0;
  logic [LEN_W-1:0] setupLen = '0;
  logic swWrEn = 1'b0, intEnable = 1'b0;
  logic [1:0] swWrData = 2'b11;
  logic [2:0] stageCode;
  logic setupValid, stageChg, stageIrq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ctlStageTop #(.LEN_W(LEN_W)) u0 (
    .clk(clk), .rstN(rstN), .hostMode(hostMode),
    .evSetup(evSetup), .evInDone(evInDone), .evOutDone(evOutDone),
    .evStatusDone(evStatusDone), .evBusReset(evBusReset),
    .setupDirIn(setupDirIn), .setupLen(setupLen),
    .swWrEn(swWrEn), .swWrData(swWrData), .intEnable(intEnable),
    .stageCode(stageCode), .setupValid(setupValid),
    .stageChg(stageChg), .stageIrq(stageIrq)
  );

  typedef struct {
    logic [2:0] stage;
    logic valid;
    logic chg;
    logic irq;
    string tag;
  } exp_t;

  exp_t expQ[$];
  logic [2:0] mStage = 3'd0;
  logic mValid = 1'b0, mChg = 1'b0;

  task automatic drive(input bit su, input bit inD, input bit outD, input bit stD,
                       input bit br, input bit dirIn, input int len,
                       input bit wrEn, input logic [1:0] wrData, input bit en,
                       input bit host, input string tag);
    logic [2:0] nS;
    exp_t e;
    @(negedge clk);
    evSetup = su; evInDone = inD; evOutDone = outD; evStatusDone = stD;
    evBusReset = br; setupDirIn = dirIn; setupLen = LEN_W'(len);
    swWrEn = wrEn; swWrData = wrData; intEnable = en; hostMode = host;
    nS = mStage;
    if (host || br) nS = 3'd0;
    else if (su) nS = dirIn ? 3'd1 : (len != 0 ? 3'd3 : 3'd5);
    else if (inD) nS = (mStage == 3'd1) ? 3'd1 : (mStage == 3'd3) ? 3'd4 : 3'd6;
    else if (outD) nS = (mStage == 3'd1) ? 3'd2 : (mStage == 3'd3) ? 3'd3 : 3'd6;
    else if (stD) nS = (mStage == 3'd2 || mStage == 3'd4 || mStage == 3'd5) ? 3'd0 : 3'd6;
    if (br) mValid = 1'b0;
    else if (su && !host) mValid = 1'b1;
    else if (wrEn && !wrData[0]) mValid = 1'b0;
    if (!host && nS != mStage) mChg = 1'b1;
    else if (wrEn && !wrData[1]) mChg = 1'b0;
    mStage = nS;
    e.stage = mStage; e.valid = mValid; e.chg = mChg; e.irq = mChg && en; e.tag = tag;
    expQ.push_back(e);
  endtask

  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      checks++;
      if (stageCode !== e.stage || setupValid !== e.valid ||
          stageChg !== e.chg || stageIrq !== e.irq) begin
        failures++;
        $display("FAIL %s: got stage=%b valid=%b chg=%b irq=%b expected stage=%b valid=%b chg=%b irq=%b",
                 e.tag, stageCode, setupValid, stageChg, stageIrq,
                 e.stage, e.valid, e.chg, e.irq);
      end
    end
  end

  task automatic idle(input bit en, input string tag);
    drive(0,0,0,0,0,0,0, 0,2'b11, en, 0, tag);
  endtask

  initial begin
    #20;
    checks++;
    if (stageCode !== 3'b000 || setupValid !== 1'b0 || stageChg !== 1'b0 || stageIrq !== 1'b0) begin
      failures++;
      $display("FAIL R1: got stage=%b valid=%b chg=%b irq=%b expected 000 0 0 0",
               stageCode, setupValid, stageChg, stageIrq);
    end
    @(negedge clk); rstN = 1'b1;
    // R2 R6: device-to-host setup
    drive(1,0,0,0,0,1,8, 0,2'b11, 0,0, "R2 R6 setup in");
    drive(0,1,0,0,0,0,0, 0,2'b11, 0,0, "R3 in keeps read data");
    drive(0,0,0,0,0,0,0, 1,2'b01, 0,0, "R8 clear chg, R7 valid kept by 1");
    drive(0,0,1,0,0,0,0, 0,2'b11, 0,0, "R3 out to read status");
    idle(1, "R9 irq enabled");
    drive(0,0,0,1,0,0,0, 0,2'b11, 1,0, "R4 status done read");
    drive(0,0,0,0,0,0,0, 1,2'b10, 1,0, "R7 clear valid");
    drive(0,0,0,0,0,0,0, 1,2'b01, 0,0, "R8 clear chg");
    // R2 write with data
    drive(1,0,0,0,0,0,4, 0,2'b11, 0,0, "R2 setup out len4");
    drive(0,0,1,0,0,0,0, 1,2'b01, 0,0, "R3 out keeps write data");
    drive(0,1,0,0,0,0,0, 0,2'b11, 0,0, "R3 in to write status");
    drive(0,0,0,1,0,0,0, 0,2'b11, 0,0, "R4 status done write");
    // no-data write
    drive(1,0,0,0,0,0,0, 0,2'b11, 0,0, "R2 setup len0");
    drive(0,0,0,1,0,0,0, 0,2'b11, 0,0, "R4 status done nodata");
    // sequence errors
    drive(0,1,0,0,0,0,0, 0,2'b11, 0,0, "R5 in while idle");
    drive(0,0,1,0,0,0,0, 1,2'b01, 1,0, "R5 out holds error");
    drive(0,0,0,1,0,0,0, 0,2'b11, 1,0, "R5 status holds error");
    drive(1,0,0,0,0,0,3, 1,2'b10, 1,0, "R6 R7 setup leaves error, beats clear");
    drive(0,0,0,1,0,0,0, 0,2'b11, 0,0, "R5 status in write data");
    drive(1,0,0,0,0,1,0, 0,2'b11, 0,0, "R2 dir in len0");
    drive(0,0,0,1,0,0,0, 1,2'b01, 0,0, "R5 R8 status in read data, change beats clear");
    // bus reset priority
    drive(1,0,0,0,1,1,8, 0,2'b11, 0,0, "R11 bus reset beats setup");
    drive(0,0,0,0,0,0,0, 1,2'b00, 0,0, "R7 R8 clear both");
    drive(1,0,0,0,0,0,5, 0,2'b11, 0,0, "R2 setup before host");
    // host mode
    drive(0,0,0,0,0,0,0, 1,2'b00, 0,1, "R10 enter host");
    drive(1,0,0,0,0,1,8, 0,2'b11, 1,1, "R10 setup ignored");
    drive(0,1,0,0,0,0,0, 0,2'b11, 1,1, "R10 in ignored");
    drive(0,0,0,0,0,0,0, 0,2'b11, 0,0, "R10 back to function");
    drive(1,0,0,0,0,1,8, 0,2'b11, 0,0, "R6 setup after host");
    idle(0, "R6 final");
    idle(0, "drain");
    @(negedge clk); @(negedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule